// File: doc/BRIEF.md
# Oscillator Retune Register-Write Sequencer

This block reprograms an external programmable clock oscillator when the frequency moves by more than ±1000 ppm, which is too far for the device to follow on its own. It takes a multiplier (9-bit integer part, 29-bit fraction) and a high-speed and a low-speed divider that were computed elsewhere. It then issues a fixed series of single-byte register writes on a request/acknowledge port that would feed a serial bus master.

On a start pulse the block latches the values. It picks the two loop-filter codes by comparing the multiplier against four fixed thresholds, and packs every field into register bytes. The writes follow a fixed order: first the output is switched off, then the new settings are written, then calibration is triggered. The block waits out the settling time and then switches the output back on. The calibration bit clears itself inside the device, so the block never reads it back. A done pulse marks the end of the series.

Top module: `osc_retune_seq`

## Requirements
- R1: A start in idle produces exactly eleven writes, to the addresses 132, 0, 5, 6, 7, 8, 9, 10, 11, 132, 132 in that order. The write to address 9 therefore follows every fractional byte.
- R2: The control writes to address 132 carry 0x00 first (output enable, bit 2, cleared), then 0x01 (calibrate, bit 0, set) and finally 0x04 (output enable set).
- R3: The fraction goes least significant byte first: address 5 holds frac[7:0], 6 holds frac[15:8] and 7 holds frac[23:16]. Address 8 holds {int[2:0], frac[28:24]}, with the integer bits in bits 7:5.
- R4: Address 9 holds {2'b00, int[8:3]}. It is written only after address 8 has been accepted.
- R5: Address 10 holds hs_div[7:0]. Address 11 holds {1'b0, ls_div[2:0], 2'b00, hs_div[9:8]}.
- R6: Address 0 holds the first loop code in bits 7:4 and the second in bits 3:0, chosen from M = int + frac/2^29:
  - M ≥ 75.843265046 gives 0x44;
  - M ≥ 72.937624981 gives 0x34;
  - M ≥ 67.859763463 gives 0x33;
  - M ≥ 65.259980246 gives 0x23;
  - any lower M gives 0x22.
- R7: A request holds its address and data unchanged until it is acknowledged. Each acknowledge completes exactly one write.
- R8: The request for the final output-enable write rises no earlier than SETTLE_CYC cycles after the calibrate write was accepted, and no more than one cycle later than that. SETTLE_CYC is the number of clock cycles in SETTLE_US microseconds, 10000 by default.
- R9: busy is high from the cycle after start until the final write is accepted. done pulses for exactly one cycle, in the first cycle that busy is low.
- R10: A start while busy is ignored. The input values seen with it are not used, and no extra writes follow the current series.
- R11: After reset, busy, done and the write request are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a retune series (ignored while busy) |
| m_int_i | input | 9 | Multiplier integer part |
| m_frac_i | input | 29 | Multiplier fractional part |
| hs_div_i | input | 10 | High-speed divider value |
| ls_div_i | input | 3 | Low-speed divider code |
| busy_o | output | 1 | Series in progress |
| done_o | output | 1 | One-cycle pulse at the end of a series |
| wr_req_o | output | 1 | Byte-write request |
| wr_addr_o | output | 8 | Register address of the request |
| wr_data_o | output | 8 | Register data of the request |
| wr_ack_i | input | 1 | Write accepted when high together with wr_req_o |

## Verification
The bench drives multipliers just above and just below the highest threshold and one vector inside each of the other bands, so a swapped or misplaced threshold shows up as a wrong byte at address 0. All-ones fractions and dividers catch fields that are shifted or truncated in bytes 8, 9 and 11. An order mistake, such as the high integer byte going out before the last fractional byte, breaks the scoreboard sequence. A settle counter that is off in length, or that is loaded at the wrong moment, moves the enable request outside its one-cycle window. A second start with different values, sent during a series, exposes a design that relatches its inputs or restarts the series.

// File: rtl/osc_retune_pkg.sv
package osc_retune_pkg;

    localparam int MI_W   = 9;
    localparam int MF_W   = 29;
    localparam int M_W    = MI_W + MF_W;
    localparam int HS_W   = 10;
    localparam int LS_W   = 3;
    localparam int NSTEP  = 11;
    localparam int STEP_W = $clog2(NSTEP);
    localparam int NTH    = 4;

    localparam logic [STEP_W-1:0] STEP_CAL = STEP_W'(9);
    localparam logic [STEP_W-1:0] STEP_ON  = STEP_W'(10);

    localparam logic [7:0] ADDR_CTRL = 8'd132;
    localparam logic [7:0] ADDR_LOOP = 8'd0;
    localparam logic [7:0] CTRL_OFF  = 8'h00;
    localparam logic [7:0] CTRL_CAL  = 8'h01;
    localparam logic [7:0] CTRL_ON   = 8'h04;

    localparam real FX_SCALE = 536870912.0;

    // ascending multiplier band edges, fixed point int.frac
    localparam logic [M_W-1:0] TH_BAND [NTH] = '{
        M_W'(longint'(65.259980246 * FX_SCALE)),
        M_W'(longint'(67.859763463 * FX_SCALE)),
        M_W'(longint'(72.937624981 * FX_SCALE)),
        M_W'(longint'(75.843265046 * FX_SCALE))
    };

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WRITE  = 2'd1,
        ST_SETTLE = 2'd2
    } seq_st_e;

    typedef struct packed {
        logic [MI_W-1:0] m_int;
        logic [MF_W-1:0] m_frac;
        logic [HS_W-1:0] hs_div;
        logic [LS_W-1:0] ls_div;
    } retune_cfg_t;

endpackage

// File: rtl/osc_loop_code_sel.sv
module osc_loop_code_sel
    import osc_retune_pkg::*;
(
    input  logic [MI_W-1:0] m_int_i,
    input  logic [MF_W-1:0] m_frac_i,
    output logic [7:0]      loop_byte_o
);
    logic [M_W-1:0] m_fx;
    logic [NTH-1:0] above;
    logic [3:0]     code_hi;
    logic [3:0]     code_lo;

    assign m_fx = {m_int_i, m_frac_i};

    for (genvar g = 0; g < NTH; g++) begin : g_cmp
        assign above[g] = (m_fx >= TH_BAND[g]);
    end

    // bands are nested, so each code steps up at alternate edges
    always_comb begin
        code_hi = 4'd2 + {3'b000, above[1]} + {3'b000, above[3]};
        code_lo = 4'd2 + {3'b000, above[0]} + {3'b000, above[2]};
        loop_byte_o = {code_hi, code_lo};
    end
endmodule

// File: rtl/osc_reg_pack.sv
module osc_reg_pack
    import osc_retune_pkg::*;
(
    input  logic [STEP_W-1:0] step_i,
    input  retune_cfg_t       cfg_i,
    input  logic [7:0]        loop_byte_i,
    output logic [7:0]        addr_o,
    output logic [7:0]        data_o
);
    always_comb begin
        addr_o = ADDR_CTRL;
        data_o = CTRL_OFF;
        case (step_i)
            STEP_W'(0): begin addr_o = ADDR_CTRL; data_o = CTRL_OFF; end
            STEP_W'(1): begin addr_o = ADDR_LOOP; data_o = loop_byte_i; end
            STEP_W'(2): begin addr_o = 8'd5; data_o = cfg_i.m_frac[7:0]; end
            STEP_W'(3): begin addr_o = 8'd6; data_o = cfg_i.m_frac[15:8]; end
            STEP_W'(4): begin addr_o = 8'd7; data_o = cfg_i.m_frac[23:16]; end
            STEP_W'(5): begin addr_o = 8'd8; data_o = {cfg_i.m_int[2:0], cfg_i.m_frac[28:24]}; end
            STEP_W'(6): begin addr_o = 8'd9; data_o = {2'b00, cfg_i.m_int[8:3]}; end
            STEP_W'(7): begin addr_o = 8'd10; data_o = cfg_i.hs_div[7:0]; end
            STEP_W'(8): begin addr_o = 8'd11; data_o = {1'b0, cfg_i.ls_div, 2'b00, cfg_i.hs_div[9:8]}; end
            STEP_CAL:   begin addr_o = ADDR_CTRL; data_o = CTRL_CAL; end
            STEP_ON:    begin addr_o = ADDR_CTRL; data_o = CTRL_ON; end
            default:    begin addr_o = ADDR_CTRL; data_o = CTRL_OFF; end
        endcase
    end
endmodule

// File: rtl/osc_settle_timer.sv
module osc_settle_timer #(
    parameter int SETTLE_CYC = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = CNT_W'(SETTLE_CYC - 1);
        else if (run_i && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/osc_retune_seq.sv
module osc_retune_seq
    import osc_retune_pkg::*;
#(
    parameter int CLK_HZ    = 1_000_000,
    parameter int SETTLE_US = 10_000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [MI_W-1:0] m_int_i,
    input  logic [MF_W-1:0] m_frac_i,
    input  logic [HS_W-1:0] hs_div_i,
    input  logic [LS_W-1:0] ls_div_i,
    output logic            busy_o,
    output logic            done_o,
    output logic            wr_req_o,
    output logic [7:0]      wr_addr_o,
    output logic [7:0]      wr_data_o,
    input  logic            wr_ack_i
);
    localparam longint SETTLE_L   = (longint'(CLK_HZ) * longint'(SETTLE_US)) / 64'd1_000_000;
    localparam int     SETTLE_CYC = (SETTLE_L < 1) ? 1 : int'(SETTLE_L);

    typedef struct packed {
        seq_st_e           st;
        logic [STEP_W-1:0] step;
        retune_cfg_t       cfg;
        logic              done;
    } seq_reg_t;

    seq_reg_t   r_d, r_q;
    logic [7:0] loop_byte;
    logic       tmr_load;
    logic       tmr_expired;
    logic       accept;

    osc_loop_code_sel u_lp (
        .m_int_i     (r_q.cfg.m_int),
        .m_frac_i    (r_q.cfg.m_frac),
        .loop_byte_o (loop_byte)
    );

    osc_reg_pack u_pack (
        .step_i      (r_q.step),
        .cfg_i       (r_q.cfg),
        .loop_byte_i (loop_byte),
        .addr_o      (wr_addr_o),
        .data_o      (wr_data_o)
    );

    osc_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .run_i     (r_q.st == ST_SETTLE),
        .expired_o (tmr_expired)
    );

    assign accept   = (r_q.st == ST_WRITE) && wr_ack_i;
    assign tmr_load = accept && (r_q.step == STEP_CAL);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.cfg  = '{m_int: m_int_i, m_frac: m_frac_i,
                                 hs_div: hs_div_i, ls_div: ls_div_i};
                    r_d.step = '0;
                    r_d.st   = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (wr_ack_i) begin
                    if (r_q.step == STEP_ON) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                        r_d.step = '0;
                    end else begin
                        r_d.step = r_q.step + 1'b1;
                        if (r_q.step == STEP_CAL)
                            r_d.st = ST_SETTLE;
                    end
                end
            end
            ST_SETTLE: begin
                if (tmr_expired)
                    r_d.st = ST_WRITE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.step <= '0;
            r_q.cfg  <= '0;
            r_q.done <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o   = (r_q.st != ST_IDLE);
    assign done_o   = r_q.done;
    assign wr_req_o = (r_q.st == ST_WRITE);
endmodule

// File: rtl/osc_retune_chk.sv
module osc_retune_chk #(
    parameter int SETTLE_CYC = 10000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy_o,
    input logic       done_o,
    input logic       wr_req_o,
    input logic [7:0] wr_addr_o,
    input logic [7:0] wr_data_o,
    input logic       wr_ack_i
);
    localparam int CW = $clog2(SETTLE_CYC + 2);

    logic          acc;
    logic [CW-1:0] since_cal_q;
    logic          seen_top_frac_q;
    logic          out_off_q;

    assign acc = wr_req_o && wr_ack_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_cal_q     <= '0;
            seen_top_frac_q <= 1'b0;
            out_off_q       <= 1'b0;
        end else begin
            if (acc && wr_addr_o == 8'd132 && wr_data_o == 8'h01)
                since_cal_q <= '0;
            else if (since_cal_q < CW'(SETTLE_CYC))
                since_cal_q <= since_cal_q + 1'b1;
            if (acc && wr_addr_o == 8'd8)
                seen_top_frac_q <= 1'b1;
            else if (acc && wr_addr_o == 8'd132 && wr_data_o == 8'h00)
                seen_top_frac_q <= 1'b0;
            if (acc && wr_addr_o == 8'd132 && wr_data_o == 8'h00)
                out_off_q <= 1'b1;
            else if (acc && wr_addr_o == 8'd132 && wr_data_o == 8'h04)
                out_off_q <= 1'b0;
        end
    end

    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o && !wr_ack_i |=> wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o));

    p_settle_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && wr_addr_o == 8'd132 && wr_data_o == 8'h04) |-> since_cal_q >= CW'(SETTLE_CYC));

    p_int_after_frac_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && wr_addr_o == 8'd9) |-> seen_top_frac_q);

    p_off_before_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && wr_addr_o == 8'd0) |-> out_off_q);

    p_done_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && $past(busy_o));

    p_req_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |-> busy_o);

    p_loop_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && wr_addr_o == 8'd0) |->
            (wr_data_o == 8'h44 || wr_data_o == 8'h34 || wr_data_o == 8'h33 ||
             wr_data_o == 8'h23 || wr_data_o == 8'h22));
endmodule

bind osc_retune_seq osc_retune_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .wr_req_o  (wr_req_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .wr_ack_i  (wr_ack_i)
);

// File: tb/sim_osc_retune_seq.sv
module sim_osc_retune_seq;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 10000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [8:0]  m_int_i = '0;
    logic [28:0] m_frac_i = '0;
    logic [9:0]  hs_div_i = '0;
    logic [2:0]  ls_div_i = '0;
    logic        busy_o, done_o, wr_req_o;
    logic [7:0]  wr_addr_o, wr_data_o;
    logic        wr_ack_i = 1'b0;

    typedef struct {
        logic [7:0] a;
        logic [7:0] d;
        string      tag;
    } wr_t;

    wr_t    expq[$];
    int     n_chk = 0;
    int     n_fail = 0;
    int     cyc = 0;
    int     cal_cyc = 0;
    int     n_wr = 0;
    bit     finished = 1'b0;

    osc_retune_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .m_int_i(m_int_i), .m_frac_i(m_frac_i),
        .hs_div_i(hs_div_i), .ls_div_i(ls_div_i),
        .busy_o(busy_o), .done_o(done_o), .wr_req_o(wr_req_o),
        .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_ack_i(wr_ack_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // driver side: expected write series from the requirements
    task automatic push_seq(input logic [8:0] mi, input logic [28:0] mf,
                            input logic [9:0] hs, input logic [2:0] ls);
        real        m;
        logic [7:0] lp;
        m = real'(mi) + real'(mf) / 536870912.0;
        if (m >= 75.843265046)      lp = 8'h44;
        else if (m >= 72.937624981) lp = 8'h34;
        else if (m >= 67.859763463) lp = 8'h33;
        else if (m >= 65.259980246) lp = 8'h23;
        else                        lp = 8'h22;
        expq.push_back('{8'd132, 8'h00, "R1/R2 off"});
        expq.push_back('{8'd0,   lp,    "R1/R6 loop"});
        expq.push_back('{8'd5,   mf[7:0],   "R1/R3 frac0"});
        expq.push_back('{8'd6,   mf[15:8],  "R1/R3 frac1"});
        expq.push_back('{8'd7,   mf[23:16], "R1/R3 frac2"});
        expq.push_back('{8'd8,   {mi[2:0], mf[28:24]}, "R1/R3 frac3"});
        expq.push_back('{8'd9,   {2'b00, mi[8:3]},     "R1/R4 int_hi"});
        expq.push_back('{8'd10,  hs[7:0],              "R1/R5 hs"});
        expq.push_back('{8'd11,  {1'b0, ls, 2'b00, hs[9:8]}, "R1/R5 ls_hs"});
        expq.push_back('{8'd132, 8'h01, "R1/R2 cal"});
        expq.push_back('{8'd132, 8'h04, "R1/R2 on"});
    endtask

    // monitor / responder: acknowledges and scores each write
    initial begin
        forever begin
            @(negedge clk);
            if (wr_req_o && !wr_ack_i) begin
                logic [7:0] a0, d0;
                wr_t        e;
                a0 = wr_addr_o;
                d0 = wr_data_o;
                if (a0 == 8'd132 && d0 == 8'h04) begin
                    check((cyc - cal_cyc) >= SETTLE + 1 && (cyc - cal_cyc) <= SETTLE + 2,
                          "R8", "settle cycles", cyc - cal_cyc, SETTLE + 1);
                end
                for (int k = 0; k < (n_wr % 3); k++) begin
                    @(negedge clk);
                    check(wr_req_o && wr_addr_o == a0 && wr_data_o == d0, "R7",
                          "held request", {wr_addr_o, wr_data_o}, {a0, d0});
                end
                n_wr++;
                if (expq.size() == 0) begin
                    check(1'b0, "R10", "unexpected write", {a0, d0}, 0);
                end else begin
                    e = expq.pop_front();
                    check(a0 == e.a && d0 == e.d, e.tag, "addr/data",
                          {a0, d0}, {e.a, e.d});
                end
                if (a0 == 8'd132 && d0 == 8'h01) cal_cyc = cyc;
                wr_ack_i = 1'b1;
                @(negedge clk);
                wr_ack_i = 1'b0;
            end
        end
    end

    task automatic run_seq(input logic [8:0] mi, input logic [28:0] mf,
                           input logic [9:0] hs, input logic [2:0] ls,
                           input bit restart_mid);
        bool_busy_ok:
        begin
            bit busy_ok;
            @(negedge clk);
            m_int_i = mi; m_frac_i = mf; hs_div_i = hs; ls_div_i = ls;
            push_seq(mi, mf, hs, ls);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            check(busy_o == 1'b1, "R9", "busy after start", busy_o, 1);
            if (restart_mid) begin
                repeat (4) @(negedge clk);
                m_int_i = ~mi; m_frac_i = ~mf; hs_div_i = ~hs; ls_div_i = ~ls;
                start_i = 1'b1;
                @(negedge clk);
                start_i = 1'b0;
            end
            busy_ok = 1'b1;
            while (!done_o) begin
                if (!busy_o) busy_ok = 1'b0;
                @(negedge clk);
            end
            check(busy_ok, "R9", "busy held through series", busy_ok, 1);
            check(busy_o == 1'b0, "R9", "busy low with done", busy_o, 0);
            check(expq.size() == 0, "R1", "writes left", expq.size(), 0);
            @(negedge clk);
            check(done_o == 1'b0, "R9", "done one cycle", done_o, 0);
            if (restart_mid) begin
                repeat (20) @(negedge clk);
                check(!busy_o && !wr_req_o, "R10", "no second series",
                      {busy_o, wr_req_o}, 0);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && !wr_req_o, "R11", "reset outputs",
              {busy_o, done_o, wr_req_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy_o && !wr_req_o, "R11", "idle after reset", {busy_o, wr_req_o}, 0);
        run_seq(9'd68, 29'h2A44557, 10'd42, 3'd0, 1'b0);
        run_seq(9'd80, 29'h1FFFFFFF, 10'h3FF, 3'd7, 1'b0);
        run_seq(9'd73, 29'h10000000, 10'h155, 3'd5, 1'b1);
        run_seq(9'd66, 29'h0, 10'h2AA, 3'd2, 1'b0);
        run_seq(9'd65, 29'h08000000, 10'd7, 3'd1, 1'b0);
        run_seq(9'd75, 29'd452730000, 10'd100, 3'd3, 1'b0);
        run_seq(9'd75, 29'd452720000, 10'd200, 3'd4, 1'b0);
        summary();
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end
endmodule